// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the receive and transmit DMA request lines of a serial port that can run with or without 16-entry FIFOs. A bus master programs a 16-bit control word that turns the FIFOs on, issues one-shot flush commands to either FIFO, picks between two request policies and chooses a receive threshold. The FIFO storage, the shifter, the baud clock and the receive timeout counter live elsewhere. This block only sees their occupancy counts, the holding-register flags used when the FIFOs are off, and a one-cycle timeout pulse.

With the simple policy the requests follow the data state directly: receive requests while anything is waiting, and transmit requests while there is room in an empty buffer. With the burst policy each request becomes a set/reset latch with hysteresis. The DMA engine is called once a useful amount has built up, or once the transmit side has drained, and it keeps being called until the buffer is fully serviced.

Top module: `uart_dma_req_gen`

## Requirements
- R1: After reset the control word reads 0x0000, both flush outputs are low, and the requests follow the holding-register flags (`rx_req = rx_hold_full`, `tx_req = tx_hold_empty`).
- R2: A write stores bit 0 (FIFO enable), bit 3 (policy: 0 simple, 1 burst) and bits 7:6 (receive threshold). Every other bit reads back as zero, so writing 0xFFFF reads back 0x00C9.
- R3: Writing 1 to bit 1 (receive flush) or bit 2 (transmit flush) raises the matching flush output for exactly the one cycle after the write. Both bits always read back as zero.
- R4: While bit 0 is 0, `rx_req = rx_hold_full` and `tx_req = tx_hold_empty`, whatever bit 3 holds.
- R5: With the FIFOs on and the simple policy, the receive request is high exactly while the receive count is non-zero.
- R6: With the FIFOs on and the simple policy, the transmit request is high exactly while the transmit count is zero.
- R7: With the burst policy, the receive request goes high in the cycle after the receive count is at or above the threshold (code 00=1, 01=4, 10=8, 11=14 entries). It then stays high until a cycle after the count is zero.
- R8: With the burst policy, a one-cycle receive timeout pulse while the receive FIFO is not empty sets the receive request in the next cycle, even when the count is below the threshold.
- R9: With the burst policy, the transmit request goes high in the cycle after the transmit count is zero. It stays high until a cycle after the count reaches 16 (full), and it does not rise again before the count returns to zero.
- R10: A flush command resets the burst-policy latch of its own direction at the write edge, so the request is low in the following cycle.
- R11: A write that changes bit 3 resets both burst-policy latches. The requests are recomputed from the inputs in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_hold_full | input | 1 | Receive holding register holds a byte (FIFOs off) |
| tx_hold_empty | input | 1 | Transmit holding register is empty (FIFOs off) |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO flush |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO flush |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The hardest state to reach from the ports is a burst-policy latch that is set while its set condition is no longer present. The hysteresis, the flush reset and the reset on a policy change can only be seen from there. The stimulus reaches it in steps. It first drives the count to the set value (zero for transmit, the threshold or a timeout for receive) for one cycle. It then moves the count to a middle value before issuing the flush or policy write, so that any request seen after that comes only from the latch.

// File: rtl/uart_dmarq_pkg.sv
package uart_dmarq_pkg;
   localparam int BIT_EN    = 0;
   localparam int BIT_RXCLR = 1;
   localparam int BIT_TXCLR = 2;
   localparam int BIT_MODE  = 3;
   localparam int BIT_TRIG  = 6;

   typedef enum logic {POL_SIMPLE = 1'b0, POL_BURST = 1'b1} policy_e;

   typedef struct packed {
      logic       fifo_en;
      policy_e    policy;
      logic [1:0] trig;
   } cfg_t;
endpackage

// File: rtl/uart_dmarq_ctrl.sv
module uart_dmarq_ctrl
   import uart_dmarq_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output cfg_t             cfg,
   output logic             rx_flush_now,
   output logic             tx_flush_now,
   output logic             policy_chg,
   output logic             rx_flush_q,
   output logic             tx_flush_q
);
   cfg_t cfg_q;

   assign rx_flush_now = wr & wdata[BIT_RXCLR];
   assign tx_flush_now = wr & wdata[BIT_TXCLR];
   assign policy_chg   = wr & (wdata[BIT_MODE] != cfg_q.policy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         rx_flush_q <= 1'b0;
         tx_flush_q <= 1'b0;
      end else begin
         rx_flush_q <= rx_flush_now;
         tx_flush_q <= tx_flush_now;
         if (wr) begin
            cfg_q.fifo_en <= wdata[BIT_EN];
            cfg_q.policy  <= policy_e'(wdata[BIT_MODE]);
            cfg_q.trig    <= wdata[BIT_TRIG+1:BIT_TRIG];
         end
      end
   end

   always_comb begin
      rdata                        = '0;
      rdata[BIT_EN]                = cfg_q.fifo_en;
      rdata[BIT_MODE]              = cfg_q.policy;
      rdata[BIT_TRIG+1:BIT_TRIG]   = cfg_q.trig;
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/uart_dmarq_trig.sv
module uart_dmarq_trig #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [1:0]       code,
   input  logic [CNT_W-1:0] count,
   output logic             at_level
);
   localparam logic [CNT_W-1:0] LVL0 = CNT_W'(1);
   localparam logic [CNT_W-1:0] LVL1 = CNT_W'(DEPTH / 4);
   localparam logic [CNT_W-1:0] LVL2 = CNT_W'(DEPTH / 2);
   localparam logic [CNT_W-1:0] LVL3 = CNT_W'(DEPTH - 2);

   logic [CNT_W-1:0] level;

   always_comb begin
      unique case (code)
         2'd0:    level = LVL0;
         2'd1:    level = LVL1;
         2'd2:    level = LVL2;
         default: level = LVL3;
      endcase
   end

   assign at_level = (count >= level);
endmodule

// File: rtl/uart_dmarq_latch.sv
module uart_dmarq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic drop,
   input  logic raise,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (flush) q <= 1'b0;
      else if (drop)  q <= 1'b0;
      else if (raise) q <= 1'b1;
   end
endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen
   import uart_dmarq_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             rx_hold_full,
   input  logic             tx_hold_empty,
   input  logic             rx_timeout,
   output logic             rx_fifo_clr,
   output logic             tx_fifo_clr,
   output logic             rx_dma_req,
   output logic             tx_dma_req
);
   localparam int NDIR = 2;
   localparam int DRX  = 0;
   localparam int DTX  = 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (REG_W < 8) begin : g_bad_regw
      $error("REG_W must be at least 8");
   end
   if (DEPTH < 8) begin : g_bad_depth
      $error("DEPTH must be at least 8");
   end

   cfg_t cfg;
   logic rx_flush_now, tx_flush_now, policy_chg;
   logic rx_at_lvl;
   logic rx_empty, tx_empty, tx_full;
   logic burst;
   logic [NDIR-1:0] l_flush, l_drop, l_raise, l_q;

   uart_dmarq_ctrl #(.REG_W(REG_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .rdata(reg_rdata), .cfg(cfg),
      .rx_flush_now(rx_flush_now), .tx_flush_now(tx_flush_now),
      .policy_chg(policy_chg),
      .rx_flush_q(rx_fifo_clr), .tx_flush_q(tx_fifo_clr)
   );

   uart_dmarq_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) trig_i (
      .code(cfg.trig), .count(rx_count), .at_level(rx_at_lvl)
   );

   assign rx_empty = (rx_count == '0);
   assign tx_empty = (tx_count == '0);
   assign tx_full  = (tx_count >= FULL_CNT);
   assign burst    = cfg.fifo_en & (cfg.policy == POL_BURST);

   assign l_flush[DRX] = rx_flush_now | policy_chg | ~cfg.fifo_en;
   assign l_flush[DTX] = tx_flush_now | policy_chg | ~cfg.fifo_en;
   assign l_drop[DRX]  = rx_empty;
   assign l_drop[DTX]  = tx_full;
   assign l_raise[DRX] = rx_at_lvl | rx_timeout;
   assign l_raise[DTX] = tx_empty;

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      uart_dmarq_latch lat_i (
         .clk(clk), .rst_n(rst_n),
         .flush(l_flush[d]), .drop(l_drop[d]), .raise(l_raise[d]),
         .q(l_q[d])
      );
   end

   always_comb begin
      if (!cfg.fifo_en) begin
         rx_dma_req = rx_hold_full;
         tx_dma_req = tx_hold_empty;
      end else if (burst) begin
         rx_dma_req = l_q[DRX];
         tx_dma_req = l_q[DTX];
      end else begin
         rx_dma_req = ~rx_empty;
         tx_dma_req = tx_empty;
      end
   end
endmodule

// File: rtl/uart_dmarq_chk.sv
module uart_dmarq_chk #(
   parameter int REG_W = 16,
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             rx_hold_full,
   input logic             tx_hold_empty,
   input logic             rx_fifo_clr,
   input logic             tx_fifo_clr,
   input logic             rx_dma_req,
   input logic             tx_dma_req
);
   logic m1;
   assign m1 = reg_rdata[0] & reg_rdata[3];

   AST_FLUSH_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2:1] == 2'b00); // R3
   AST_RX_FLUSH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[1]) |=> rx_fifo_clr); // R3
   AST_TX_FLUSH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[2]) |=> tx_fifo_clr); // R3
   AST_OFF_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[0] |-> (rx_dma_req == rx_hold_full)); // R4
   AST_OFF_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[0] |-> (tx_dma_req == tx_hold_empty)); // R4
   AST_SIMPLE_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[0] && !reg_rdata[3]) |-> (rx_dma_req == (rx_count != '0))); // R5
   AST_SIMPLE_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[0] && !reg_rdata[3]) |-> (tx_dma_req == (tx_count == '0))); // R6
   AST_BURST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (m1 && rx_dma_req && rx_count != '0 && !reg_wr) |=> rx_dma_req); // R7
   AST_BURST_TX_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (m1 && tx_count == CNT_W'(DEPTH) && !reg_wr) |=> !tx_dma_req); // R9
endmodule

bind uart_dma_req_gen uart_dmarq_chk #(.REG_W(REG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .rx_count(rx_count), .tx_count(tx_count),
   .rx_hold_full(rx_hold_full), .tx_hold_empty(tx_hold_empty),
   .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
   .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
);

// File: tb/uart_dma_req_gen_tb_top.sv
`timescale 1ns/1ps
module uart_dma_req_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [4:0]  rx_count = '0;
   logic [4:0]  tx_count = 5'd5;
   logic        rx_hold_full = 1'b0;
   logic        tx_hold_empty = 1'b0;
   logic        rx_timeout = 1'b0;
   logic        rx_fifo_clr, tx_fifo_clr, rx_dma_req, tx_dma_req;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   uart_dma_req_gen dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rx_count(rx_count), .tx_count(tx_count),
      .rx_hold_full(rx_hold_full), .tx_hold_empty(tx_hold_empty),
      .rx_timeout(rx_timeout), .rx_fifo_clr(rx_fifo_clr),
      .tx_fifo_clr(tx_fifo_clr), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [15:0] v);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic t_reset();
      rx_hold_full = 1'b1; tx_hold_empty = 1'b0;
      #1;
      check("R1 rdata", reg_rdata, 16'h0000);
      check("R1 clr", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
      check("R1 rx_req", rx_dma_req, 1'b1);
      check("R1 tx_req", tx_dma_req, 1'b0);
   endtask

   task automatic t_regmap();
      wr_reg(16'hFFFF);
      check("R2 readback", reg_rdata, 16'h00C9);
      check("R3 flush pulse", {rx_fifo_clr, tx_fifo_clr}, 2'b11);
      step();
      check("R3 flush one cycle", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
      wr_reg(16'h0000);
   endtask

   task automatic t_disabled();
      wr_reg(16'h0008);
      rx_hold_full = 1'b0; tx_hold_empty = 1'b1; rx_count = 5'd3; tx_count = 5'd0;
      step();
      check("R4 rx off", rx_dma_req, 1'b0);
      check("R4 tx off", tx_dma_req, 1'b1);
      rx_hold_full = 1'b1; tx_hold_empty = 1'b0;
      step();
      check("R4 rx off hold", rx_dma_req, 1'b1);
      check("R4 tx off hold", tx_dma_req, 1'b0);
   endtask

   task automatic t_simple();
      wr_reg(16'h0001);
      rx_count = 5'd0; tx_count = 5'd0; step();
      check("R5 rx empty", rx_dma_req, 1'b0);
      check("R6 tx empty", tx_dma_req, 1'b1);
      rx_count = 5'd3; tx_count = 5'd5; step();
      check("R5 rx data", rx_dma_req, 1'b1);
      check("R6 tx data", tx_dma_req, 1'b0);
   endtask

   task automatic t_burst_rx();
      rx_count = 5'd0; tx_count = 5'd5;
      wr_reg(16'h0049);
      rx_count = 5'd3; step(); step();
      check("R7 below level", rx_dma_req, 1'b0);
      rx_count = 5'd4; step();
      check("R7 at level", rx_dma_req, 1'b1);
      rx_count = 5'd1; step();
      check("R7 hysteresis", rx_dma_req, 1'b1);
      rx_count = 5'd0; step();
      check("R7 drop empty", rx_dma_req, 1'b0);
      wr_reg(16'h00C9);
      rx_count = 5'd13; step();
      check("R7 below 14", rx_dma_req, 1'b0);
      rx_count = 5'd14; step();
      check("R7 at 14", rx_dma_req, 1'b1);
      rx_count = 5'd0; step();
   endtask

   task automatic t_timeout();
      rx_count = 5'd2; rx_timeout = 1'b1; step();
      rx_timeout = 1'b0;
      check("R8 timeout set", rx_dma_req, 1'b1);
      step();
      check("R8 timeout held", rx_dma_req, 1'b1);
      rx_count = 5'd0; step();
      check("R8 drop", rx_dma_req, 1'b0);
   endtask

   task automatic t_burst_tx();
      tx_count = 5'd0; step();
      check("R9 empty set", tx_dma_req, 1'b1);
      tx_count = 5'd8; step();
      check("R9 hold", tx_dma_req, 1'b1);
      tx_count = 5'd16; step();
      check("R9 full drop", tx_dma_req, 1'b0);
      tx_count = 5'd3; step();
      check("R9 no rise", tx_dma_req, 1'b0);
   endtask

   task automatic t_flush();
      tx_count = 5'd0; step(); tx_count = 5'd8; step();
      check("R10 tx latched", tx_dma_req, 1'b1);
      wr_reg(16'h00CD);
      check("R10 tx flushed", tx_dma_req, 1'b0);
      check("R10 tx pulse", tx_fifo_clr, 1'b1);
      rx_count = 5'd14; step(); rx_count = 5'd5; step();
      check("R10 rx latched", rx_dma_req, 1'b1);
      wr_reg(16'h00CB);
      check("R10 rx flushed", rx_dma_req, 1'b0);
      rx_count = 5'd0;
   endtask

   task automatic t_policy();
      tx_count = 5'd0; step(); tx_count = 5'd8; step();
      check("R11 tx latched", tx_dma_req, 1'b1);
      wr_reg(16'h00C1);
      check("R11 simple now", tx_dma_req, 1'b0);
      tx_count = 5'd0;
      wr_reg(16'h00C9);
      check("R11 latch reset", tx_dma_req, 1'b0);
      step();
      check("R11 recomputed", tx_dma_req, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_disabled();
      t_simple();
      t_burst_rx();
      t_timeout();
      t_burst_tx();
      t_flush();
      t_policy();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule